// File: doc/BRIEF.md
# Boundary-Scan Pad Register Chain

This block is the boundary-scan data register for a row of `N_PADS` bidirectional pads. Each pad has three scan cells: output enable, output data and input data. Two non-pad control cells sit at the serial-output end of the chain and one non-pad flag cell sits at the serial-input end. Every cell has a capture/shift flop and an update latch. The chain is `3*N_PADS+3` bits long.

A TAP controller outside the block supplies the capture, shift and update strobes, plus two mode levels. `extest` puts the pads under scan control. `bscan_active` says that a boundary-scan instruction is selected. While `extest` is high, the update latches drive the pad output and enable values in place of the core. At all other times the core values pass through. Pads that carry TAP inputs are named in a parameter mask, and their output enable is forced off whenever `bscan_active` is high. The core input always comes straight from the pin, and scan data never replaces it.

Top module: `bscan_chain`

## Requirements
- R1: After asynchronous reset, every shift cell and update latch holds 0, `ctl_upd` is 0, and with `extest` low the pad outputs follow the core.
- R2: On each rising `tck` with `shift_dr` high and `capture_dr` low, cell k takes the value of cell k+1, the last cell takes `tdi`, and `tdo_ser` always shows cell 0.
- R3: The chain is exactly `3*N_PADS+3` cells long. A bit shifted in at `tdi` leaves at `tdo_ser` after that many shifts.
- R4: On a rising `tck` with `capture_dr` high, cells load in parallel: cells 0, 1 and the last cell load 0. For pad p, cell 2+3p loads the driven `pad_oe[p]`, cell 3+3p loads the driven `pad_out[p]`, and cell 4+3p loads `pad_in[p]`. Capture takes priority over shift.
- R5: On a rising `tck` with `update_dr` high, every update latch loads its shift cell. `ctl_upd` shows the latches of cell 0 (bit 0), cell 1 (bit 1) and the last cell (bit 2).
- R6: While `extest` is high, `pad_out[p]` equals the update latch of cell 3+3p, and `pad_oe[p]` equals the latch of cell 2+3p, unless R8 applies.
- R7: While `extest` is low, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`, unless R8 applies. Update latch contents have no effect.
- R8: For a pad whose `TAP_PAD_MASK` bit is set, `pad_oe` is 0 whenever `bscan_active` is high, in either mode.
- R9: `core_in` always equals `pad_in`, whatever the mode or the scan contents.
- R10: A rising `tck` with neither `capture_dr` nor `shift_dr` leaves every shift cell unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial scan input |
| capture_dr | input | 1 | Parallel capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update latch strobe |
| extest | input | 1 | Pads driven from the update latches |
| bscan_active | input | 1 | A boundary-scan instruction is selected |
| core_out | input | N_PADS | Core output data per pad |
| core_oe | input | N_PADS | Core output enable per pad |
| pad_in | input | N_PADS | Value seen on each pin |
| pad_out | output | N_PADS | Output data to each pad driver |
| pad_oe | output | N_PADS | Output enable to each pad driver |
| core_in | output | N_PADS | Pin value passed to the core |
| tdo_ser | output | 1 | Serial scan output (cell 0) |
| ctl_upd | output | 3 | Update latches of the three non-pad cells |

## Verification
A wrong shift cell shows up on `tdo_ser` after the number of shifts that separates that cell from cell 0. A capture that lands in the wrong position shows up as a bit out of place within one chain length of shifting. A wrong update latch shows up on `pad_out`, `pad_oe` or `ctl_upd` in the same cycle that `extest` is raised after the update. A missing TAP-pad guard shows up on `pad_oe` the moment `bscan_active` rises.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_PADS = 4,
  parameter logic [N_PADS-1:0] TAP_PAD_MASK = '0
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tdi,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              extest,
  input  logic              bscan_active,
  input  logic [N_PADS-1:0] core_out,
  input  logic [N_PADS-1:0] core_oe,
  input  logic [N_PADS-1:0] pad_in,
  output logic [N_PADS-1:0] pad_out,
  output logic [N_PADS-1:0] pad_oe,
  output logic [N_PADS-1:0] core_in,
  output logic              tdo_ser,
  output logic [2:0]        ctl_upd
);
  localparam int LEN = 3*N_PADS + 3;

  logic [LEN-1:0] sr, upd, cap;

  always_comb begin
    cap = '0;
    for (int p = 0; p < N_PADS; p++) begin
      cap[2+3*p] = pad_oe[p];
      cap[3+3*p] = pad_out[p];
      cap[4+3*p] = pad_in[p];
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          sr <= '0;
    else if (capture_dr) sr <= cap;
    else if (shift_dr)   sr <= {tdi, sr[LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)         upd <= '0;
    else if (update_dr) upd <= sr;
  end

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    logic guard;
    assign guard      = TAP_PAD_MASK[p] && bscan_active;
    assign pad_out[p] = extest ? upd[3+3*p] : core_out[p];
    assign pad_oe[p]  = guard ? 1'b0 : (extest ? upd[2+3*p] : core_oe[p]);
  end

  assign core_in = pad_in;
  assign tdo_ser = sr[0];
  assign ctl_upd = {upd[LEN-1], upd[1], upd[0]};
endmodule

module bscan_chain_chk #(
  parameter int N_PADS = 4,
  parameter logic [N_PADS-1:0] TAP_PAD_MASK = '0
) (
  input logic                  tck,
  input logic                  rst_n,
  input logic                  capture_dr,
  input logic                  shift_dr,
  input logic                  update_dr,
  input logic                  bscan_active,
  input logic [3*N_PADS+2:0]   sr,
  input logic                  tdo_ser,
  input logic [2:0]            ctl_upd,
  input logic [N_PADS-1:0]     pad_oe
);
  localparam int LEN = 3*N_PADS + 3;

  p_shift_moves_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_dr && !capture_dr) |=> tdo_ser == $past(sr[1]));

  p_idle_holds_r10: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_dr && !capture_dr) |=> $stable(sr));

  p_update_ctl_r5: assert property (@(posedge tck) disable iff (!rst_n)
    update_dr |=> ctl_upd == {$past(sr[LEN-1]), $past(sr[1]), $past(sr[0])});

  for (genvar p = 0; p < N_PADS; p++) begin : g_tap
    if (TAP_PAD_MASK[p]) begin : g_on
      p_tap_pad_off_r8: assert property (@(posedge tck) disable iff (!rst_n)
        bscan_active |-> !pad_oe[p]);
    end
  end
endmodule

bind bscan_chain bscan_chain_chk #(.N_PADS(N_PADS), .TAP_PAD_MASK(TAP_PAD_MASK)) u_chk (
  .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
  .update_dr(update_dr), .bscan_active(bscan_active), .sr(sr),
  .tdo_ser(tdo_ser), .ctl_upd(ctl_upd), .pad_oe(pad_oe)
);

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int L = 3*N + 3;
  localparam logic [N-1:0] TAPM = 4'b0010;

  logic tck = 0, rst_n = 0, tdi = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic extest = 0, bscan_active = 0;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, core_in;
  logic tdo_ser;
  logic [2:0] ctl_upd;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  bscan_chain #(.N_PADS(N), .TAP_PAD_MASK(TAPM)) i_bscan_chain (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [L-1:0] din, output logic [L-1:0] dout);
    for (int i = 0; i < L; i++) begin
      @(negedge tck);
      tdi = din[i]; shift_dr = 1;
      dout[i] = tdo_ser;
    end
    @(negedge tck);
    shift_dr = 0;
  endtask

  task automatic pulse_capture();
    @(negedge tck); capture_dr = 1;
    @(negedge tck); capture_dr = 0;
  endtask

  task automatic pulse_update();
    @(negedge tck); update_dr = 1;
    @(negedge tck); update_dr = 0;
  endtask

  function automatic logic [L-1:0] pat(input int s);
    logic [31:0] v;
    v = (s * 32'h9E3779B1) ^ (s << 7) ^ 32'h5A5A;
    return v[L-1:0];
  endfunction

  task automatic run();
    logic [L-1:0] got, dummy, exp, p;
    logic [N-1:0] oe_eff;
    #(CLK_PERIOD*2);
    chk(tdo_ser === 1'b0 && ctl_upd === 3'b0, "R1 reset scan", {tdo_ser, ctl_upd}, 0);
    core_out = 4'b1010; core_oe = 4'b0110;
    #1;
    chk(pad_out === core_out && pad_oe === core_oe, "R1 reset pads", {pad_out, pad_oe}, {core_out, core_oe});
    @(negedge tck); rst_n = 1;
    shift_word('0, got);
    chk(got === '0, "R1 reset chain", got, 0);

    // R2/R3 round trips
    for (int s = 1; s < 9; s++) begin
      p = pat(s);
      shift_word(p, dummy);
      shift_word(~p, got);
      chk(got === p, "R2 R3 round trip", got, p);
    end

    // R10 hold over idle clocks
    p = pat(42);
    shift_word(p, dummy);
    repeat (5) @(negedge tck);
    shift_word('0, got);
    chk(got === p, "R10 idle hold", got, p);

    // R4 capture sweep, R9 core_in
    for (int s = 0; s < 32; s++) begin
      core_out = s[3:0]; core_oe = s[3:0] ^ 4'b0101; pad_in = ~s[3:0] + s[4];
      bscan_active = s[4]; extest = 0;
      #1;
      chk(core_in === pad_in, "R9 core_in", core_in, pad_in);
      oe_eff = core_oe & ~(TAPM & {N{bscan_active}});
      exp = '0;
      for (int q = 0; q < N; q++) begin
        exp[2+3*q] = oe_eff[q]; exp[3+3*q] = core_out[q]; exp[4+3*q] = pad_in[q];
      end
      shift_word(pat(s+100), dummy);
      pulse_capture();
      shift_word('0, got);
      chk(got === exp, "R4 capture", got, exp);
    end

    // R5 R6 R7 R8 update and override
    for (int s = 0; s < 16; s++) begin
      p = pat(s + 300);
      core_out = s[3:0]; core_oe = ~s[3:0];
      extest = 0; bscan_active = s[0];
      shift_word(p, dummy);
      pulse_update();
      #1;
      chk(ctl_upd === {p[L-1], p[1], p[0]}, "R5 ctl_upd", ctl_upd, {p[L-1], p[1], p[0]});
      oe_eff = core_oe & ~(TAPM & {N{bscan_active}});
      chk(pad_out === core_out && pad_oe === oe_eff, "R7 core pass", {pad_out, pad_oe}, {core_out, oe_eff});
      extest = 1;
      #1;
      for (int q = 0; q < N; q++) begin
        logic eo;
        eo = (TAPM[q] && bscan_active) ? 1'b0 : p[2+3*q];
        chk(pad_out[q] === p[3+3*q], "R6 extest out", pad_out[q], p[3+3*q]);
        chk(pad_oe[q] === eo, "R6 R8 extest oe", pad_oe[q], eo);
      end
      bscan_active = 1;
      #1;
      chk(pad_oe[1] === 1'b0, "R8 tap pad off", pad_oe[1], 0);
      // R9 pin data survives scan override
      pad_in = ~pad_in;
      #1;
      chk(core_in === pad_in, "R9 extest core_in", core_in, pad_in);
      extest = 0;
    end
  endtask

  initial begin
    fork
      run();
      begin
        #(CLK_PERIOD*100000);
        chk(1'b0, "WATCHDOG", 0, 1);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule